// File: doc/BRIEF.md
# Quasi-Bidirectional Port Group with Pin-Sampled Bit Operations

This block holds the port-side state of a small controller: an 8-line bidirectional port, a 4-line input-only port and an 8-line output-only port. The CPU side talks to it through a 2-bit port select, a 3-bit operation code, a bit index and a write-data byte, and sees a read-data byte chosen by the same select. The pin side gets, per line, an active-high drive-low enable and a pull-up enable, and gives back the resolved pin level.

A bidirectional line is quasi-bidirectional. A latch value of 0 pulls the pin low. A latch value of 1 releases the pin to a weak pull-up, and any outside device may still pull it low. A read returns the live pin level after a two-flop synchronizer, not the latch. Bit set and bit clear on this port rebuild the whole latch from the sampled pins, so a line that an outside device holds low ends up latched low. Lines chosen by parameter are open-drain and never get the internal pull-up. The block has no state machine: each port is one latch register that a decoded operation updates.

Top module: `qport_group`

## Requirements
- R1: While reset_n is low and after it rises, every latch holds all ones: bd_drive_low and out_drive_low are 0, bd_pullup_en equals the inverse of BD_OD_MASK (0x7F by default), out_pullup_en equals the inverse of OUT_OD_MASK (0xF0 by default), and a read of the bidirectional port with no external pull-down returns 0xFF.
- R2: A write (cpu_op 1) with cpu_sel 2 loads the bidirectional latch from cpu_wdata on the next clock edge; bd_drive_low is then the inverse of the latch and bd_pullup_en is the latch ANDed with the inverse of BD_OD_MASK.
- R3: A read with cpu_sel 2 returns the bidirectional pin levels, not the latch, delayed by exactly two clock edges through the synchronizer; an external pull-down changes the read value but not the latch.
- R4: Bit set (cpu_op 3) and bit clear (cpu_op 4) with cpu_sel 2 load the latch with the synchronized pin byte with bit cpu_bit set or cleared, so a line held low from outside becomes latched low and stays low after the outside device lets go.
- R5: A read with cpu_sel 0 returns the four synchronized input lines in bits 3..0 and zero in bits 7..4; any operation with cpu_sel 0 changes no output of the block.
- R6: With cpu_sel 1, a write loads the output-only latch from cpu_wdata and a clear (cpu_op 2) loads zero; bit set and bit clear are ignored; a read returns zero.
- R7: Lines set in BD_OD_MASK or OUT_OD_MASK never assert their pull-up enable; in_pullup_en equals IN_PULLUP_MASK (0x3 by default) at all times.
- R8: A bit operation issued in the cycle after a write to the same port uses the pin sample taken before that write reached the pins, and a read in the cycle of a write returns the old pin level.
- R9: With cpu_op 0 (idle), or codes 5 to 7, no latch changes, even while pin levels move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| reset_n | input | 1 | Master clear, active low, sets all latches to one |
| cpu_sel | input | 2 | Port select: 0 input-only, 1 output-only, 2 bidirectional, 3 none |
| cpu_op | input | 3 | 0 idle, 1 write, 2 clear, 3 bit set, 4 bit clear |
| cpu_bit | input | 3 | Bit index for bit set and bit clear |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected port |
| bd_pin_in | input | 8 | Resolved levels of the bidirectional pins |
| bd_drive_low | output | 8 | Pull bidirectional pin low when 1 |
| bd_pullup_en | output | 8 | Enable weak pull-up on bidirectional pin |
| in_pin_in | input | 4 | Levels of the input-only pins |
| in_pullup_en | output | 4 | Pull-up enable for input-only pins |
| out_drive_low | output | 8 | Pull output-only pin low when 1 |
| out_pullup_en | output | 8 | Pull-up enable for output-only pin |

## Verification
The assertions take for granted that pin inputs are driven to known levels from reset onward, since the synchronizer check compares its output with the pin value two edges back, and that the CPU holds one operation per cycle, changed away from the clock edge. The bench keeps to this by modelling each bidirectional pin as a wired-AND of the block's drive, its pull-up, an external pull-up and an external pull-down, all known from time zero, and by changing every CPU input and external pin level only on the falling clock edge.

// File: rtl/qport_pkg.sv
package qport_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_CLEAR = 3'd2,
        OP_BSET  = 3'd3,
        OP_BCLR  = 3'd4
    } port_op_e;

    typedef enum logic [1:0] {
        SEL_IN   = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_BD   = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

endpackage

// File: rtl/qport_sync.sv
module qport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         reset_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    // Data flops carry no reset: they only ever hold sampled pin levels.
    always_ff @(posedge clk) begin
        stage_q[0] <= din;
        for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!reset_n)
                dout == $past(din, 2));
        end
    endgenerate

endmodule

// File: rtl/qport_latch.sv
module qport_latch
    import qport_pkg::*;
#(
    parameter int             W       = 8,
    parameter int             IDX_W   = 3,
    parameter bit             RMW_EN  = 1'b1,
    parameter logic [W-1:0]   OD_MASK = '0
) (
    input  logic             clk,
    input  logic             reset_n,
    input  logic             sel,
    input  port_op_e         op,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pin_sync,
    output logic [W-1:0]     drive_low,
    output logic [W-1:0]     pullup_en
);

    logic [W-1:0] latch_q;
    logic [W-1:0] latch_nxt;
    logic [W-1:0] bit_mask;
    logic [W-1:0] rmw_set;
    logic [W-1:0] rmw_clr;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bit_mask[i] = (bit_idx == IDX_W'(i));
        end
    end

    generate
        if (RMW_EN) begin : g_rmw
            // Whole byte comes from the pins, not from the latch.
            assign rmw_set = pin_sync | bit_mask;
            assign rmw_clr = pin_sync & ~bit_mask;
        end else begin : g_no_rmw
            assign rmw_set = latch_q;
            assign rmw_clr = latch_q;
        end
    endgenerate

    always_comb begin
        latch_nxt = latch_q;
        if (sel) begin
            case (op)
                OP_WRITE: latch_nxt = wdata;
                OP_CLEAR: latch_nxt = '0;
                OP_BSET:  latch_nxt = rmw_set;
                OP_BCLR:  latch_nxt = rmw_clr;
                default:  latch_nxt = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            latch_q <= '1;
        end else begin
            latch_q <= latch_nxt;
        end
    end

    assign drive_low = ~latch_q;
    assign pullup_en = latch_q & ~OD_MASK;

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!reset_n)
        (sel && op == OP_WRITE) |=> drive_low == ~$past(wdata));

    assert_clear_loads_R6: assert property (@(posedge clk) disable iff (!reset_n)
        (sel && op == OP_CLEAR) |=> drive_low == '1);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!reset_n)
        (!sel || op == OP_IDLE) |=> $stable(drive_low));

    generate
        if (RMW_EN) begin : g_rmw_chk
            assert_bset_from_pins_R4: assert property (@(posedge clk) disable iff (!reset_n)
                (sel && op == OP_BSET) |=> (~drive_low) == ($past(pin_sync) | $past(bit_mask)));
            assert_bclr_from_pins_R4: assert property (@(posedge clk) disable iff (!reset_n)
                (sel && op == OP_BCLR) |=> (~drive_low) == ($past(pin_sync) & ~$past(bit_mask)));
        end else begin : g_no_rmw_chk
            assert_bitop_ignored_R6: assert property (@(posedge clk) disable iff (!reset_n)
                (sel && (op == OP_BSET || op == OP_BCLR)) |=> $stable(drive_low));
        end
    endgenerate

endmodule

// File: rtl/qport_group.sv
module qport_group
    import qport_pkg::*;
#(
    parameter int                 DATA_W         = 8,
    parameter int                 BD_W           = 8,
    parameter int                 IN_W           = 4,
    parameter int                 OUT_W          = 8,
    parameter int                 SYNC_STAGES    = 2,
    parameter logic [BD_W-1:0]    BD_OD_MASK     = 8'h80,
    parameter logic [OUT_W-1:0]   OUT_OD_MASK    = 8'h0F,
    parameter logic [IN_W-1:0]    IN_PULLUP_MASK = 4'b0011
) (
    input  logic              clk,
    input  logic              reset_n,
    input  logic [1:0]        cpu_sel,
    input  logic [2:0]        cpu_op,
    input  logic [2:0]        cpu_bit,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [BD_W-1:0]   bd_pin_in,
    output logic [BD_W-1:0]   bd_drive_low,
    output logic [BD_W-1:0]   bd_pullup_en,
    input  logic [IN_W-1:0]   in_pin_in,
    output logic [IN_W-1:0]   in_pullup_en,
    output logic [OUT_W-1:0]  out_drive_low,
    output logic [OUT_W-1:0]  out_pullup_en
);

    localparam int IDX_W = $clog2(DATA_W);

    port_op_e   op;
    port_sel_e  sel;
    logic [BD_W-1:0] bd_sync;
    logic [IN_W-1:0] in_sync;

    assign op  = port_op_e'(cpu_op);
    assign sel = port_sel_e'(cpu_sel);

    qport_sync #(.W(BD_W), .STAGES(SYNC_STAGES)) u_bd_sync (
        .clk     (clk),
        .reset_n (reset_n),
        .din     (bd_pin_in),
        .dout    (bd_sync)
    );

    qport_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk     (clk),
        .reset_n (reset_n),
        .din     (in_pin_in),
        .dout    (in_sync)
    );

    qport_latch #(.W(BD_W), .IDX_W(IDX_W), .RMW_EN(1'b1), .OD_MASK(BD_OD_MASK)) u_bd_latch (
        .clk       (clk),
        .reset_n   (reset_n),
        .sel       (sel == SEL_BD),
        .op        (op),
        .bit_idx   (cpu_bit),
        .wdata     (cpu_wdata[BD_W-1:0]),
        .pin_sync  (bd_sync),
        .drive_low (bd_drive_low),
        .pullup_en (bd_pullup_en)
    );

    // Output-only port has no input path: its pin sample is tied off.
    qport_latch #(.W(OUT_W), .IDX_W(IDX_W), .RMW_EN(1'b0), .OD_MASK(OUT_OD_MASK)) u_out_latch (
        .clk       (clk),
        .reset_n   (reset_n),
        .sel       (sel == SEL_OUT),
        .op        (op),
        .bit_idx   (cpu_bit),
        .wdata     (cpu_wdata[OUT_W-1:0]),
        .pin_sync  ({OUT_W{1'b0}}),
        .drive_low (out_drive_low),
        .pullup_en (out_pullup_en)
    );

    assign in_pullup_en = IN_PULLUP_MASK;

    always_comb begin
        cpu_rdata = '0;
        case (sel)
            SEL_IN:  cpu_rdata[IN_W-1:0] = in_sync;
            SEL_BD:  cpu_rdata[BD_W-1:0] = bd_sync;
            default: cpu_rdata = '0;
        endcase
    end

    assert_in_ops_no_effect_R5: assert property (@(posedge clk) disable iff (!reset_n)
        (sel == SEL_IN) |=> ($stable(bd_drive_low) && $stable(out_drive_low)));

    assert_od_no_pullup_R7: assert property (@(posedge clk) disable iff (!reset_n)
        (sel == SEL_BD && op == OP_WRITE) |=> (bd_pullup_en & BD_OD_MASK) == '0);

endmodule

// File: tb/qport_group_tb.sv
module qport_group_tb;

    logic       clk = 1'b0;
    logic       reset_n = 1'b0;
    logic [1:0] cpu_sel = 2'd3;
    logic [2:0] cpu_op = 3'd0;
    logic [2:0] cpu_bit = 3'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] bd_pin_in;
    logic [7:0] bd_drive_low;
    logic [7:0] bd_pullup_en;
    logic [3:0] in_pin_in;
    logic [3:0] in_pullup_en;
    logic [7:0] out_drive_low;
    logic [7:0] out_pullup_en;

    logic [7:0] ext_low  = 8'h00;
    logic [7:0] ext_high = 8'h80;
    logic [3:0] in_ext   = 4'h0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // Wired-AND pin model.
    assign bd_pin_in = ~bd_drive_low & (bd_pullup_en | ext_high) & ~ext_low;
    assign in_pin_in = in_ext;

    qport_group u_dut (
        .clk           (clk),
        .reset_n       (reset_n),
        .cpu_sel       (cpu_sel),
        .cpu_op        (cpu_op),
        .cpu_bit       (cpu_bit),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .bd_pin_in     (bd_pin_in),
        .bd_drive_low  (bd_drive_low),
        .bd_pullup_en  (bd_pullup_en),
        .in_pin_in     (in_pin_in),
        .in_pullup_en  (in_pullup_en),
        .out_drive_low (out_drive_low),
        .out_pullup_en (out_pullup_en)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Issue one operation; returns at the falling edge after it took effect.
    task automatic do_op(input logic [1:0] s, input logic [2:0] o, input logic [2:0] b, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_op = o; cpu_bit = b; cpu_wdata = d;
        @(negedge clk);
        cpu_op = 3'd0; cpu_sel = 2'd3;
    endtask

    task automatic read_port(input logic [1:0] s, output logic [7:0] v);
        cpu_sel = s;
        #1 v = cpu_rdata;
        cpu_sel = 2'd3;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1", "bd_drive_low in reset", bd_drive_low, 8'h00);
        check("R1", "out_drive_low in reset", out_drive_low, 8'h00);
        @(negedge clk); reset_n = 1'b1;
        idle(3);
        check("R1", "bd_pullup_en", bd_pullup_en, 8'h7F);
        check("R1", "out_pullup_en", out_pullup_en, 8'hF0);
        read_port(2'd2, v);
        check("R1", "bd read after reset", v, 8'hFF);
    endtask

    task automatic t_write;
        logic [7:0] v;
        do_op(2'd2, 3'd1, 3'd0, 8'hA5);
        check("R2", "bd_drive_low after write", bd_drive_low, 8'h5A);
        check("R2", "bd_pullup_en after write", bd_pullup_en, 8'h25);
        idle(3);
        read_port(2'd2, v);
        check("R2", "bd read follows pins", v, 8'hA5);
    endtask

    task automatic t_ext_read;
        logic [7:0] v;
        do_op(2'd2, 3'd1, 3'd0, 8'hFF);
        ext_low = 8'h0C;
        idle(3);
        read_port(2'd2, v);
        check("R3", "bd read with pull-down", v, 8'hF3);
        check("R3", "latch untouched by pins", bd_drive_low, 8'h00);
        ext_low = 8'h00;
        idle(3);
    endtask

    task automatic t_sync_delay;
        logic [7:0] v;
        @(negedge clk); ext_low = 8'h40;
        @(negedge clk);
        read_port(2'd2, v);
        check("R3", "read after one edge", v, 8'hFF);
        @(negedge clk);
        read_port(2'd2, v);
        check("R3", "read after two edges", v, 8'hBF);
        ext_low = 8'h00;
        idle(3);
    endtask

    task automatic t_rmw;
        logic [7:0] v;
        do_op(2'd2, 3'd1, 3'd0, 8'hFF);
        ext_low = 8'h01;
        idle(3);
        do_op(2'd2, 3'd3, 3'd5, 8'h00);
        check("R4", "bset relatches held-low bit", bd_drive_low, 8'h01);
        ext_low = 8'h00;
        idle(3);
        read_port(2'd2, v);
        check("R4", "bit stays low after release", v, 8'hFE);
        do_op(2'd2, 3'd1, 3'd0, 8'hFF);
        idle(3);
        do_op(2'd2, 3'd4, 3'd3, 8'h00);
        check("R4", "bclr bit 3", bd_drive_low, 8'h08);
        do_op(2'd2, 3'd1, 3'd0, 8'hFF);
        idle(3);
    endtask

    task automatic t_same_cycle;
        logic [7:0] v;
        @(negedge clk);
        cpu_sel = 2'd2; cpu_op = 3'd1; cpu_wdata = 8'h0F;
        #1 v = cpu_rdata;
        check("R8", "read during write is old", v, 8'hFF);
        @(negedge clk);
        cpu_op = 3'd3; cpu_bit = 3'd7;
        @(negedge clk);
        cpu_op = 3'd0; cpu_sel = 2'd3;
        check("R8", "bset uses stale sample", bd_drive_low, 8'h00);
        idle(3);
    endtask

    task automatic t_in_port;
        logic [7:0] v;
        in_ext = 4'b1010;
        idle(3);
        read_port(2'd0, v);
        check("R5", "input port read", v, 8'h0A);
        do_op(2'd0, 3'd1, 3'd0, 8'h55);
        do_op(2'd0, 3'd3, 3'd2, 8'h00);
        check("R5", "bd latch untouched", bd_drive_low, 8'h00);
        check("R5", "out latch untouched", out_drive_low, 8'h00);
        read_port(2'd0, v);
        check("R5", "input read unchanged", v, 8'h0A);
    endtask

    task automatic t_out_port;
        logic [7:0] v;
        do_op(2'd1, 3'd1, 3'd0, 8'h3C);
        check("R6", "out write", out_drive_low, 8'hC3);
        check("R6", "out pullup", out_pullup_en, 8'h30);
        do_op(2'd1, 3'd3, 3'd0, 8'h00);
        check("R6", "bset on out ignored", out_drive_low, 8'hC3);
        do_op(2'd1, 3'd4, 3'd2, 8'h00);
        check("R6", "bclr on out ignored", out_drive_low, 8'hC3);
        read_port(2'd1, v);
        check("R6", "out read zero", v, 8'h00);
        do_op(2'd1, 3'd2, 3'd0, 8'hFF);
        check("R6", "out clear", out_drive_low, 8'hFF);
        do_op(2'd1, 3'd1, 3'd0, 8'hFF);
    endtask

    task automatic t_open_drain;
        logic [7:0] v;
        ext_high = 8'h00;
        idle(3);
        read_port(2'd2, v);
        check("R7", "od line floats low", v, 8'h7F);
        check("R7", "od bd pullup off", bd_pullup_en, 8'h7F);
        check("R7", "od out pullup off", out_pullup_en, 8'hF0);
        check("R7", "input pullups", {4'h0, in_pullup_en}, 8'h03);
        ext_high = 8'h80;
        idle(3);
        read_port(2'd2, v);
        check("R7", "od line external high", v, 8'hFF);
    endtask

    task automatic t_idle;
        do_op(2'd2, 3'd1, 3'd0, 8'h96);
        ext_low = 8'h02;
        do_op(2'd3, 3'd3, 3'd1, 8'h00);
        do_op(2'd2, 3'd6, 3'd1, 8'h00);
        idle(4);
        check("R9", "bd latch held", bd_drive_low, 8'h69);
        check("R9", "out latch held", out_drive_low, 8'h00);
        ext_low = 8'h00;
    endtask

    initial begin
        idle(4);
        t_reset;
        t_write;
        t_ext_read;
        t_sync_delay;
        t_rmw;
        t_same_cycle;
        t_in_port;
        t_out_port;
        t_open_drain;
        t_idle;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule